// File: doc/BRIEF.md
# Idle Sleep and Wake Controller

This block decides when a capacitive-sensing device may power down and when it must come back. While awake, it counts slow idle ticks (nominally 15.6 ms each) against a programmable stay-awake count. Any button press or I2C activity restarts that count. When the count runs out, the block drops into either timed sleep or deep sleep, as selected by an enable input.

In timed sleep the block counts fast time-base ticks for one of four selectable intervals. At the end of each interval it spends one cycle in a scan state that asks the measurement logic for a sensor scan, then goes back to sleep. A GPIO interrupt, a button press or I2C activity brings it straight back to Awake. Deep sleep has no periodic wake. Only a GPIO interrupt or the sleep pin pulled low ends it, and the block then passes through a fixed wake-up delay, nominally 127 µs, before it accepts I2C traffic again.

The same wake-up delay runs after reset. The states are Awake, Sleep, Scan, Deep and Waking. The transitions are:
- Idle timeout: Awake to Sleep, or Awake to Deep.
- Interval end: Sleep to Scan.
- Scan done: Scan to Sleep.
- Early wake: Sleep or Scan to Awake.
- Pin or interrupt wake: Deep to Waking.
- Delay end: Waking to Awake.

Top module: `pwr_idle_ctrl`

## Requirements
- R1: While reset is asserted, `state_o` reads Waking. The state codes are Awake=0, Sleep=1, Scan=2, Deep=3 and Waking=4. While in reset, `i2c_ready_o` and `scan_req_o` are both low.
- R2: Waking lasts exactly WAKE_TICKS fast ticks. The clock edge that samples the last of them moves the block to Awake.
- R3: In Awake with a stay-awake count N of 1 or more and no activity, the N-th idle tick moves the block to Sleep when `deep_en_i` is 0, or to Deep when it is 1.
- R4: A stay-awake count of 0 ends Awake on the first idle tick.
- R5: A button press or I2C activity in Awake reloads the idle count from `stay_cnt_i`. If activity and an idle tick arrive in the same cycle, the activity wins and the tick is not counted.
- R6: In Sleep, the block moves to Scan once the selected number of fast ticks has passed. The interval select codes are 00 for INTV_T0 (nominally 1.95 ms), 01 for INTV_T1 (15.6 ms), 10 for INTV_T2 (125 ms) and 11 for INTV_T3 (1 s). The select is sampled on the last cycle before Sleep is entered. Scan lasts one cycle with `scan_req_o` high, then the block returns to Sleep with a fresh interval.
- R7: `i2c_ready_o` is high in Awake, Sleep and Scan, and low in Deep and Waking.
- R8: In Sleep or Scan, a GPIO interrupt, a button press or I2C activity moves the block to Awake on the next edge.
- R9: In Deep there is no scan request. Idle ticks, fast ticks, button presses and I2C activity leave the state unchanged.
- R10: In Deep, a GPIO interrupt or a low level on `sleep_pin_n_i` moves the block to Waking on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idle_tick_i | input | 1 | One-cycle pulse per idle period (15.6 ms) |
| fast_tick_i | input | 1 | One-cycle pulse of the fast time base |
| stay_cnt_i | input | SAC_W | Stay-awake count in idle ticks |
| intv_sel_i | input | 2 | Sleep interval select |
| deep_en_i | input | 1 | Idle timeout enters Deep instead of Sleep |
| btn_act_i | input | 1 | Button press seen |
| i2c_act_i | input | 1 | I2C activity seen |
| gpio_irq_i | input | 1 | GPIO interrupt |
| sleep_pin_n_i | input | 1 | Sleep control pin, low wakes from Deep |
| state_o | output | 3 | Current state code |
| scan_req_o | output | 1 | Scan request, high for one cycle in Scan |
| i2c_ready_o | output | 1 | Block accepts I2C traffic |

## Verification
Every state change is registered once, so the outputs show the result of a stimulus or tick one clock edge after the edge that sampled it. The bench applies inputs on falling edges and compares all three outputs with its model on the following falling edge. Durations are measured in ticks, not cycles: the bench counts the fast or idle ticks sampled on rising edges between entry into a state and the falling edge where the next state first shows. That count is compared with the stay-awake count, the selected interval or WAKE_TICKS. The test of a tick and activity arriving together drives the activity on the exact cycle of a tick that would otherwise end Awake.

// File: rtl/pwr_idle_pkg.sv
package pwr_idle_pkg;

    // Power-state codes; the numeric values are visible on state_o.
    typedef enum logic [2:0] {
        PS_AWAKE  = 3'd0,
        PS_SLEEP  = 3'd1,
        PS_SCAN   = 3'd2,
        PS_DEEP   = 3'd3,
        PS_WAKING = 3'd4
    } pwr_state_e;

endpackage

// File: rtl/pwr_dn_timer.sv
// Loadable down-counter that flags the step that exhausts it.
module pwr_dn_timer #(
    parameter int         W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic         step,
    output logic         done
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RST_VAL;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && step && (cnt_q != '0)) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    // A loaded value of 0 or 1 both expire on the first step.
    assign done = run & step & ~load & (cnt_q <= W'(1));

endmodule

// File: rtl/pwr_intv_sel.sv
// Maps the 2-bit interval code to a fast-tick count.
module pwr_intv_sel #(
    parameter int W  = 20,
    parameter int T0 = 1950,
    parameter int T1 = 15600,
    parameter int T2 = 125000,
    parameter int T3 = 1000000
) (
    input  logic [1:0]   sel,
    output logic [W-1:0] val
);

    always_comb begin
        unique case (sel)
            2'd0: val = W'(T0);
            2'd1: val = W'(T1);
            2'd2: val = W'(T2);
            2'd3: val = W'(T3);
        endcase
    end

endmodule

// File: rtl/pwr_idle_ctrl.sv
module pwr_idle_ctrl
    import pwr_idle_pkg::*;
#(
    parameter int SAC_W      = 8,
    parameter int INTV_T0    = 1950,
    parameter int INTV_T1    = 15600,
    parameter int INTV_T2    = 125000,
    parameter int INTV_T3    = 1000000,
    parameter int WAKE_TICKS = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_tick_i,
    input  logic             fast_tick_i,
    input  logic [SAC_W-1:0] stay_cnt_i,
    input  logic [1:0]       intv_sel_i,
    input  logic             deep_en_i,
    input  logic             btn_act_i,
    input  logic             i2c_act_i,
    input  logic             gpio_irq_i,
    input  logic             sleep_pin_n_i,
    output logic [2:0]       state_o,
    output logic             scan_req_o,
    output logic             i2c_ready_o
);

    localparam int MAX_T = (INTV_T3 > WAKE_TICKS) ? INTV_T3 : WAKE_TICKS;
    localparam int CNT_W = $clog2(MAX_T + 1);

    pwr_state_e state_q, state_d;

    logic             act_any;
    logic             wake_light;
    logic             wake_deep;
    logic             idle_done;
    logic             intv_done;
    logic             wake_done;
    logic [CNT_W-1:0] intv_val;

    assign act_any    = btn_act_i | i2c_act_i;
    assign wake_light = act_any | gpio_irq_i;
    assign wake_deep  = gpio_irq_i | ~sleep_pin_n_i;

    // Idle timer: reloaded outside Awake and on any activity.
    pwr_dn_timer #(
        .W       (SAC_W),
        .RST_VAL ('0)
    ) u_idle_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     ((state_q != PS_AWAKE) | act_any),
        .load_val (stay_cnt_i),
        .run      (state_q == PS_AWAKE),
        .step     (idle_tick_i),
        .done     (idle_done)
    );

    pwr_intv_sel #(
        .W  (CNT_W),
        .T0 (INTV_T0),
        .T1 (INTV_T1),
        .T2 (INTV_T2),
        .T3 (INTV_T3)
    ) u_intv_sel (
        .sel (intv_sel_i),
        .val (intv_val)
    );

    // Sleep interval timer: select is captured on the cycle before Sleep.
    pwr_dn_timer #(
        .W       (CNT_W),
        .RST_VAL ('0)
    ) u_intv_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q != PS_SLEEP),
        .load_val (intv_val),
        .run      (state_q == PS_SLEEP),
        .step     (fast_tick_i),
        .done     (intv_done)
    );

    // Wake-up delay timer, preloaded at reset because reset enters Waking.
    pwr_dn_timer #(
        .W       (CNT_W),
        .RST_VAL (CNT_W'(WAKE_TICKS))
    ) u_wake_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q != PS_WAKING),
        .load_val (CNT_W'(WAKE_TICKS)),
        .run      (state_q == PS_WAKING),
        .step     (fast_tick_i),
        .done     (wake_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_WAKING;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_AWAKE: begin
                if (idle_done) begin
                    state_d = deep_en_i ? PS_DEEP : PS_SLEEP;
                end
            end
            PS_SLEEP: begin
                if (wake_light) begin
                    state_d = PS_AWAKE;
                end else if (intv_done) begin
                    state_d = PS_SCAN;
                end
            end
            PS_SCAN: begin
                state_d = wake_light ? PS_AWAKE : PS_SLEEP;
            end
            PS_DEEP: begin
                if (wake_deep) begin
                    state_d = PS_WAKING;
                end
            end
            PS_WAKING: begin
                if (wake_done) begin
                    state_d = PS_AWAKE;
                end
            end
            default: state_d = PS_WAKING;
        endcase
    end

    always_comb begin
        state_o     = state_q;
        scan_req_o  = (state_q == PS_SCAN);
        i2c_ready_o = (state_q != PS_DEEP) && (state_q != PS_WAKING);
    end

endmodule

// File: rtl/pwr_idle_ctrl_chk.sv
module pwr_idle_ctrl_chk
    import pwr_idle_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       deep_en_i,
    input logic       btn_act_i,
    input logic       i2c_act_i,
    input logic       gpio_irq_i,
    input logic       sleep_pin_n_i,
    input logic [2:0] state_o,
    input logic       scan_req_o,
    input logic       i2c_ready_o
);

    localparam logic [2:0] C_AWAKE  = PS_AWAKE;
    localparam logic [2:0] C_SLEEP  = PS_SLEEP;
    localparam logic [2:0] C_SCAN   = PS_SCAN;
    localparam logic [2:0] C_DEEP   = PS_DEEP;
    localparam logic [2:0] C_WAKING = PS_WAKING;

    AST_SCAN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_req_o |=> !scan_req_o); // R6

    AST_SCAN_AFTER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_req_o) |-> $past(state_o) == C_SLEEP); // R6

    AST_READY_FROM_WAKING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(i2c_ready_o) |-> $past(state_o) == C_WAKING); // R2

    AST_ACT_HOLDS_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == C_AWAKE && (btn_act_i || i2c_act_i)) |=> state_o == C_AWAKE); // R5

    AST_NO_DEEP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == C_AWAKE && !deep_en_i) |=> state_o != C_DEEP); // R3

    AST_LIGHT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == C_SLEEP || state_o == C_SCAN) && (gpio_irq_i || btn_act_i || i2c_act_i))
        |=> state_o == C_AWAKE); // R8

    AST_DEEP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == C_DEEP && !gpio_irq_i && sleep_pin_n_i) |=> state_o == C_DEEP); // R9

    AST_DEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == C_DEEP && (gpio_irq_i || !sleep_pin_n_i)) |=> state_o == C_WAKING); // R10

endmodule

bind pwr_idle_ctrl pwr_idle_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .deep_en_i     (deep_en_i),
    .btn_act_i     (btn_act_i),
    .i2c_act_i     (i2c_act_i),
    .gpio_irq_i    (gpio_irq_i),
    .sleep_pin_n_i (sleep_pin_n_i),
    .state_o       (state_o),
    .scan_req_o    (scan_req_o),
    .i2c_ready_o   (i2c_ready_o)
);

// File: tb/pwr_idle_ctrl_bench.sv
module pwr_idle_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int T0 = 3;
    localparam int T1 = 5;
    localparam int T2 = 9;
    localparam int T3 = 17;
    localparam int WT = 4;

    localparam int S_AWAKE  = 0;
    localparam int S_SLEEP  = 1;
    localparam int S_SCAN   = 2;
    localparam int S_DEEP   = 3;
    localparam int S_WAKING = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fast_tick;
    logic       idle_tick;
    logic [7:0] stay_cnt = 8'd3;
    logic [1:0] intv_sel = 2'd0;
    logic       deep_en = 1'b0;
    logic       btn_act = 1'b0;
    logic       i2c_act = 1'b0;
    logic       gpio_irq = 1'b0;
    logic       sleep_pin_n = 1'b1;
    logic [2:0] state_o;
    logic       scan_req_o;
    logic       i2c_ready_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    string cur_req = "R1";

    int unsigned cyc = 0;
    int f_seen = 0;
    int i_seen = 0;
    int scan_seen = 0;

    int m_st = S_WAKING;
    int m_idle = 0;
    int m_intv = 0;
    int m_wake = WT;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign fast_tick = cyc[0];
    assign idle_tick = (cyc % 6) == 5;

    pwr_idle_ctrl #(
        .SAC_W      (8),
        .INTV_T0    (T0),
        .INTV_T1    (T1),
        .INTV_T2    (T2),
        .INTV_T3    (T3),
        .WAKE_TICKS (WT)
    ) u_pwr_idle_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .idle_tick_i   (idle_tick),
        .fast_tick_i   (fast_tick),
        .stay_cnt_i    (stay_cnt),
        .intv_sel_i    (intv_sel),
        .deep_en_i     (deep_en),
        .btn_act_i     (btn_act),
        .i2c_act_i     (i2c_act),
        .gpio_irq_i    (gpio_irq),
        .sleep_pin_n_i (sleep_pin_n),
        .state_o       (state_o),
        .scan_req_o    (scan_req_o),
        .i2c_ready_o   (i2c_ready_o)
    );

    function automatic int intv_of(input int s);
        case (s)
            0: return T0;
            1: return T1;
            2: return T2;
            default: return T3;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Time base and tick bookkeeping, sampled where the design samples.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (fast_tick) f_seen++;
            if (idle_tick) i_seen++;
            if (scan_req_o) scan_seen++;
        end
    end

    // Behavioural reference model, one step per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = S_WAKING;
            m_wake = WT;
            m_idle = 0;
            m_intv = 0;
        end else begin
            int nst;
            bit act;
            act = btn_act || i2c_act;
            nst = m_st;
            if (m_st == S_AWAKE && !act && idle_tick && m_idle <= 1)
                nst = deep_en ? S_DEEP : S_SLEEP;
            else if (m_st == S_SLEEP) begin
                if (act || gpio_irq) nst = S_AWAKE;
                else if (fast_tick && m_intv <= 1) nst = S_SCAN;
            end else if (m_st == S_SCAN)
                nst = (act || gpio_irq) ? S_AWAKE : S_SLEEP;
            else if (m_st == S_DEEP && (gpio_irq || !sleep_pin_n))
                nst = S_WAKING;
            else if (m_st == S_WAKING && fast_tick && m_wake <= 1)
                nst = S_AWAKE;
            if (m_st != S_AWAKE || act) m_idle = stay_cnt;
            else if (idle_tick && m_idle > 0) m_idle--;
            if (m_st != S_SLEEP) m_intv = intv_of(intv_sel);
            else if (fast_tick && m_intv > 0) m_intv--;
            if (m_st != S_WAKING) m_wake = WT;
            else if (fast_tick && m_wake > 0) m_wake--;
            m_st = nst;
        end
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(cur_req, "model state", int'(state_o), m_st);
            check(cur_req, "model scan", int'(scan_req_o), int'(m_st == S_SCAN));
            check(cur_req, "model ready", int'(i2c_ready_o),
                  int'(m_st != S_DEEP && m_st != S_WAKING));
        end
    end

    task automatic wait_state(input int target, input string req);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (int'(state_o) != target && n < 3000);
        if (n >= 3000) check(req, "timeout waiting for state", int'(state_o), target);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int f0;
        int i0;
        int s0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "reset state", int'(state_o), S_WAKING);
        check("R1", "reset ready", int'(i2c_ready_o), 0);
        check("R1", "reset scan", int'(scan_req_o), 0);
        rst_n = 1'b1;

        // R2: wake-up delay after reset, ready low until it ends (R7)
        cur_req = "R2";
        f0 = f_seen;
        wait_state(S_AWAKE, "R2");
        check("R2", "fast ticks in Waking", f_seen - f0, WT);
        check("R7", "ready in Awake", int'(i2c_ready_o), 1);

        // R3: idle timeout with count 3 into Sleep
        cur_req = "R3";
        i0 = i_seen;
        wait_state(S_SLEEP, "R3");
        check("R3", "idle ticks to Sleep", i_seen - i0, 3);
        check("R7", "ready in Sleep", int'(i2c_ready_o), 1);

        // R6: each interval code
        cur_req = "R6";
        for (int s = 0; s < 4; s++) begin
            intv_sel = 2'(s);
            wait_state(S_SCAN, "R6");
            check("R6", "scan request in Scan", int'(scan_req_o), 1);
            check("R7", "ready in Scan", int'(i2c_ready_o), 1);
            @(negedge clk);
            check("R6", "back to Sleep after one cycle", int'(state_o), S_SLEEP);
            check("R6", "scan request dropped", int'(scan_req_o), 0);
            f0 = f_seen;
            wait_state(S_SCAN, "R6");
            check("R6", "fast ticks for interval code", f_seen - f0, intv_of(s));
        end

        // R8: GPIO interrupt ends Scan/Sleep; R4: zero count
        cur_req = "R8";
        stay_cnt = 8'd0;
        @(negedge clk);
        pulse(gpio_irq);
        check("R8", "gpio wakes from Sleep", int'(state_o), S_AWAKE);
        cur_req = "R4";
        i0 = i_seen;
        wait_state(S_SLEEP, "R4");
        check("R4", "idle ticks with count 0", i_seen - i0, 1);

        // R8 with a button press; R5 reload, activity on a tick cycle
        cur_req = "R5";
        stay_cnt = 8'd2;
        pulse(btn_act);
        check("R8", "button wakes from Sleep", int'(state_o), S_AWAKE);
        i0 = i_seen;
        while (i_seen - i0 < 1) @(negedge clk);
        while (!idle_tick) @(negedge clk);
        i2c_act = 1'b1;
        @(negedge clk);
        i2c_act = 1'b0;
        check("R5", "activity on tick keeps Awake", int'(state_o), S_AWAKE);
        i0 = i_seen;
        wait_state(S_SLEEP, "R5");
        check("R5", "idle ticks after reload", i_seen - i0, 2);

        // R3 deep branch, R9 ignored inputs, R10 pin wake
        cur_req = "R9";
        deep_en = 1'b1;
        stay_cnt = 8'd1;
        pulse(gpio_irq);
        check("R8", "gpio wakes again", int'(state_o), S_AWAKE);
        wait_state(S_DEEP, "R3");
        check("R3", "timeout with deep enable", int'(state_o), S_DEEP);
        check("R7", "ready in Deep", int'(i2c_ready_o), 0);
        s0 = scan_seen;
        pulse(btn_act);
        pulse(i2c_act);
        repeat (2 * T3 + 10) @(negedge clk);
        check("R9", "state after button, I2C and ticks", int'(state_o), S_DEEP);
        check("R9", "scan requests in Deep", scan_seen - s0, 0);

        cur_req = "R10";
        pulse(sleep_pin_n_inv_dummy);
        check("R10", "sleep pin low leaves Deep", int'(state_o), S_WAKING);
        check("R7", "ready in Waking", int'(i2c_ready_o), 0);
        f0 = f_seen;
        wait_state(S_AWAKE, "R2");
        check("R2", "fast ticks in Waking after Deep", f_seen - f0, WT);

        wait_state(S_DEEP, "R3");
        pulse(gpio_irq);
        check("R10", "gpio leaves Deep", int'(state_o), S_WAKING);
        wait_state(S_AWAKE, "R2");
        check("R2", "ready after wake delay", int'(i2c_ready_o), 1);

        repeat (4) @(negedge clk);
        summary();
    end

    // Active-high helper driving the active-low sleep pin.
    logic sleep_pin_n_inv_dummy = 1'b0;
    always_comb sleep_pin_n = ~sleep_pin_n_inv_dummy;

endmodule